// File: doc/BRIEF.md
# VCO Voltage-Table Linearity Checker

This block checks a calibration sweep that maps applied supply voltage to a ring-oscillator count. Entries arrive one per handshake, in order of rising voltage. Each entry is a voltage code and the count measured at that voltage. The block compares every entry with the one before it. The voltage must rise strictly and the count must rise with it. The slope, in counts per voltage code, must stay inside a programmed window. A count that fails to rise would let one count stand for two voltages, so the voltage reading could no longer be trusted for power estimation.

A start pulse arms the block and clears any previous result. The driving firmware then streams the table and marks the final entry. One cycle after that entry is accepted, the block raises done. It also shows a pass flag, a fault code and the zero-based index of the entry that closed the first bad step. Only that first fault is kept. The check does not depend on where the reference voltage comes from, so it behaves the same when a fixed external reference stands in for the on-package one.

Top module: `vco_lin_checker`

## Requirements
- R1: After reset, in_ready, done and pass are low, and fault_code and fault_idx are 0.
- R2: A start pulse clears done, pass, fault_code and fault_idx in the next cycle, and in_ready is high from that cycle on.
- R3: An entry is taken when in_valid and in_ready are both high. When the taken entry has in_last set, done is high and in_ready is low from the next cycle on. Entries offered while done is high change nothing.
- R4: If the voltage rises and the count falls relative to the previous entry, the fault code is 1 (count decreased).
- R5: If the voltage rises and the count is equal to the previous count, the fault code is 2 (count flat).
- R6: If the voltage code is not strictly greater than the previous one, the fault code is 5 (voltage order). This check overrides all count checks.
- R7: Gain is delta_count / delta_voltage, in fixed point with FRAC fractional bits. If (delta_count << FRAC) < gain_min * delta_voltage, the fault code is 3 (gain low). Equality passes.
- R8: If (delta_count << FRAC) > gain_max * delta_voltage, the fault code is 4 (gain high). Equality passes.
- R9: Only the first faulty step is recorded. fault_idx is the zero-based index of the later entry of that step, and later faults in the same sweep do not change fault_code or fault_idx.
- R10: pass is high exactly when done is high and no fault was recorded. A table of a single entry passes with no gain check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the result and arms a new sweep |
| gain_min | input | GW | Lowest allowed gain, with FRAC fractional bits |
| gain_max | input | GW | Highest allowed gain, with FRAC fractional bits |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Block accepts entries |
| in_volt | input | VW | Voltage code of the entry |
| in_count | input | CW | VCO count of the entry |
| in_last | input | 1 | Marks the final entry of the sweep |
| done | output | 1 | Sweep finished, result valid |
| pass | output | 1 | Sweep passed |
| fault_code | output | 3 | 0 pass, 1 decreased, 2 flat, 3 gain low, 4 gain high, 5 voltage order |
| fault_idx | output | IW | Index of the entry that closed the first faulty step |

## Verification
A wrong previous-entry register would show as a fault code on the step that follows it. It becomes visible on fault_code one cycle after that entry is taken, even if done has not yet risen. A sticky-latch error would show at the end of the sweep, when a later fault replaces the first one in fault_code and fault_idx. An off-by-one in the index counter would show on fault_idx in the cycle the fault is recorded. A sequencing error would show as done rising late, or as in_ready still high while done is high, one cycle after the last entry.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_DEC  = 3'd1,
    FLT_FLAT = 3'd2,
    FLT_LOW  = 3'd3,
    FLT_HIGH = 3'd4,
    FLT_VORD = 3'd5
  } fault_e;
endpackage

// File: rtl/vlc_step_eval.sv
// Combinational judgement of one step between the previous and current entry.
module vlc_step_eval #(
  parameter int VW   = 12,
  parameter int CW   = 16,
  parameter int GW   = 12,
  parameter int FRAC = 4
) (
  input  logic              have_prev,
  input  logic [VW-1:0]     prev_volt,
  input  logic [CW-1:0]     prev_count,
  input  logic [VW-1:0]     cur_volt,
  input  logic [CW-1:0]     cur_count,
  input  logic [GW-1:0]     gain_min,
  input  logic [GW-1:0]     gain_max,
  output vlc_pkg::fault_e   step_code
);
  import vlc_pkg::*;

  localparam int LW = CW + FRAC;
  localparam int RW = GW + VW;
  localparam int PW = ((LW > RW) ? LW : RW) + 1;

  logic [VW-1:0] dv;
  logic [CW-1:0] dc;
  logic [PW-1:0] lhs;
  logic [PW-1:0] rmin;
  logic [PW-1:0] rmax;
  logic          v_bad;
  logic          c_dec;
  logic          c_flat;

  assign dv     = cur_volt - prev_volt;
  assign dc     = cur_count - prev_count;
  assign v_bad  = (cur_volt <= prev_volt);
  assign c_dec  = (cur_count < prev_count);
  assign c_flat = (cur_count == prev_count);

  generate
    if (FRAC == 0) begin : g_nofrac
      assign lhs = PW'(dc);
    end else begin : g_frac
      assign lhs = PW'(dc) << FRAC;
    end
  endgenerate

  assign rmin = PW'(gain_min) * PW'(dv);
  assign rmax = PW'(gain_max) * PW'(dv);

  always_comb begin
    step_code = FLT_NONE;
    if (have_prev) begin
      if (v_bad)            step_code = FLT_VORD;
      else if (c_dec)       step_code = FLT_DEC;
      else if (c_flat)      step_code = FLT_FLAT;
      else if (lhs < rmin)  step_code = FLT_LOW;
      else if (lhs > rmax)  step_code = FLT_HIGH;
    end
  end

  // R6: an order fault never coexists with a pass code on a compared step
  always_comb begin
    a_r6_order_wins: assert (!(have_prev && v_bad) || step_code == FLT_VORD)
      else $error("a_r6_order_wins");
  end
endmodule

// File: rtl/vlc_ctrl.sv
// Sweep sequencing: handshake, entry index and previous-entry storage.
module vlc_ctrl #(
  parameter int VW = 12,
  parameter int CW = 16,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [VW-1:0] in_volt,
  input  logic [CW-1:0] in_count,
  output logic          in_ready,
  output logic          take,
  output logic          take_last,
  output logic          done,
  output logic          have_prev,
  output logic [IW-1:0] idx,
  output logic [VW-1:0] prev_volt,
  output logic [CW-1:0] prev_count
);
  logic ready_q;
  logic done_q;

  assign in_ready  = ready_q;
  assign done      = done_q;
  assign take      = in_valid && ready_q && !start;
  assign take_last = take && in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      done_q     <= 1'b0;
      have_prev  <= 1'b0;
      idx        <= '0;
      prev_volt  <= '0;
      prev_count <= '0;
    end else if (start) begin
      ready_q    <= 1'b1;
      done_q     <= 1'b0;
      have_prev  <= 1'b0;
      idx        <= '0;
    end else if (take) begin
      have_prev  <= 1'b1;
      prev_volt  <= in_volt;
      prev_count <= in_count;
      idx        <= idx + 1'b1;
      if (in_last) begin
        ready_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  a_r3_ready_excl_done: assert property (@(posedge clk) disable iff (rst)
    !(ready_q && done_q));
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    take_last |=> (done_q && !ready_q));
  a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
    start |=> (ready_q && !done_q && idx == '0));
endmodule

// File: rtl/vlc_fault_latch.sv
// Keeps only the first fault code and the index where it happened.
module vlc_fault_latch #(
  parameter int IW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ev,
  input  vlc_pkg::fault_e code_in,
  input  logic [IW-1:0]   idx_in,
  output vlc_pkg::fault_e code_q,
  output logic [IW-1:0]   idx_q
);
  import vlc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code_q <= FLT_NONE;
      idx_q  <= '0;
    end else if (ev && code_q == FLT_NONE && code_in != FLT_NONE) begin
      code_q <= code_in;
      idx_q  <= idx_in;
    end
  end

  a_r9_first_sticky: assert property (@(posedge clk) disable iff (rst)
    (code_q != FLT_NONE && !clr) |=> ($stable(code_q) && $stable(idx_q)));
endmodule

// File: rtl/vco_lin_checker.sv
module vco_lin_checker #(
  parameter int VW          = 12,
  parameter int CW          = 16,
  parameter int GW          = 12,
  parameter int FRAC        = 4,
  parameter int MAX_ENTRIES = 256,
  localparam int IW         = (MAX_ENTRIES > 2) ? $clog2(MAX_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [GW-1:0] gain_min,
  input  logic [GW-1:0] gain_max,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_volt,
  input  logic [CW-1:0] in_count,
  input  logic          in_last,
  output logic          done,
  output logic          pass,
  output logic [2:0]    fault_code,
  output logic [IW-1:0] fault_idx
);
  import vlc_pkg::*;

  logic          take;
  logic          take_last;
  logic          have_prev;
  logic [IW-1:0] idx;
  logic [VW-1:0] prev_volt;
  logic [CW-1:0] prev_count;
  fault_e        step_code;
  fault_e        lat_code;
  logic          pass_q;

  vlc_ctrl #(.VW(VW), .CW(CW), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .in_valid(in_valid), .in_last(in_last),
    .in_volt(in_volt), .in_count(in_count),
    .in_ready(in_ready), .take(take), .take_last(take_last),
    .done(done), .have_prev(have_prev), .idx(idx),
    .prev_volt(prev_volt), .prev_count(prev_count)
  );

  vlc_step_eval #(.VW(VW), .CW(CW), .GW(GW), .FRAC(FRAC)) u_eval (
    .have_prev(have_prev), .prev_volt(prev_volt), .prev_count(prev_count),
    .cur_volt(in_volt), .cur_count(in_count),
    .gain_min(gain_min), .gain_max(gain_max),
    .step_code(step_code)
  );

  vlc_fault_latch #(.IW(IW)) u_latch (
    .clk(clk), .rst(rst), .clr(start), .ev(take),
    .code_in(step_code), .idx_in(idx),
    .code_q(lat_code), .idx_q(fault_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || start) pass_q <= 1'b0;
    else if (take_last) pass_q <= (lat_code == FLT_NONE) && (step_code == FLT_NONE);
  end

  assign pass       = pass_q;
  assign fault_code = lat_code;

  a_r10_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && fault_code == 3'd0));
  a_r4_dec_flagged: assert property (@(posedge clk) disable iff (rst)
    (take && have_prev && lat_code == FLT_NONE && in_volt > prev_volt
     && in_count < prev_count) |=> (fault_code == 3'd1 && fault_idx == $past(idx)));
endmodule

// File: tb/vco_lin_checker_tb.sv
module vco_lin_checker_tb;
  localparam int VW = 12, CW = 16, GW = 12, FRAC = 4, IW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [GW-1:0] gain_min = 12'd128;   // 8.0 counts per code
  logic [GW-1:0] gain_max = 12'd192;   // 12.0 counts per code
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_volt = '0;
  logic [CW-1:0] in_count = '0;
  logic          in_last = 1'b0;
  logic          done, pass;
  logic [2:0]    fault_code;
  logic [IW-1:0] fault_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int tv [0:7];
  int tc [0:7];

  always #5 clk = ~clk;

  vco_lin_checker #(.VW(VW), .CW(CW), .GW(GW), .FRAC(FRAC), .MAX_ENTRIES(256)) u_dut (
    .clk(clk), .rst(rst), .start(start), .gain_min(gain_min), .gain_max(gain_max),
    .in_valid(in_valid), .in_ready(in_ready), .in_volt(in_volt), .in_count(in_count),
    .in_last(in_last), .done(done), .pass(pass), .fault_code(fault_code),
    .fault_idx(fault_idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // streams tv/tc[0..n-1], last on final entry; returns at the negedge after it
  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_volt = VW'(tv[i]); in_count = CW'(tc[i]);
      in_last = (i == n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic result(input string req, input int code, input int idx, input int ps);
    chk(req, "done", int'(done), 1);
    chk(req, "ready", int'(in_ready), 0);
    chk(req, "code", int'(fault_code), code);
    chk(req, "idx", int'(fault_idx), idx);
    chk(req, "pass", int'(pass), ps);
  endtask

  task automatic load_good();
    for (int i = 0; i < 4; i++) begin tv[i] = 1000 + 8*i; tc[i] = 21000 + 80*i; end
  endtask

  task automatic t_reset();
    chk("R1", "ready", int'(in_ready), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pass", int'(pass), 0);
    chk("R1", "code", int'(fault_code), 0);
    chk("R1", "idx", int'(fault_idx), 0);
  endtask

  task automatic t_good();
    load_good(); do_start();
    chk("R2", "ready after start", int'(in_ready), 1);
    sweep(4); result("R10", 0, 0, 1);
  endtask

  task automatic t_dec();
    tv[0]=999; tv[1]=1007; tv[2]=1015; tv[3]=1023;
    tc[0]=21311; tc[1]=21391; tc[2]=21389; tc[3]=21469;
    do_start(); sweep(4); result("R4", 1, 2, 0);
  endtask

  task automatic t_flat();
    load_good(); tc[1] = tc[0];
    tc[2] = tc[1] + 80; tc[3] = tc[2] + 80;
    do_start(); sweep(4); result("R5", 2, 1, 0);
  endtask

  task automatic t_vord();
    load_good(); tv[2] = tv[1];   // equal voltage, count still rises
    do_start(); sweep(4); result("R6", 5, 2, 0);
  endtask

  task automatic t_low();
    load_good(); tc[3] = tc[2] + 40;   // 640 < 1024
    do_start(); sweep(4); result("R7", 3, 3, 0);
  endtask

  task automatic t_high();
    load_good(); tc[1] = tc[0] + 200;  // 3200 > 1536
    tc[2] = tc[1] + 80; tc[3] = tc[2] + 80;
    do_start(); sweep(4); result("R8", 4, 1, 0);
  endtask

  task automatic t_edges();
    load_good(); tc[1] = tc[0] + 64;   // exactly min
    tc[2] = tc[1] + 96;                 // exactly max
    tc[3] = tc[2] + 80;
    do_start(); sweep(4); result("R7 R8 boundary", 0, 0, 1);
  endtask

  task automatic t_first();
    load_good(); tc[1] = tc[0] + 40;   // gain low at 1
    tc[2] = tc[1] + 80; tc[3] = tc[2] - 5; // decrease at 3
    do_start(); sweep(4); result("R9", 3, 1, 0);
  endtask

  task automatic t_midfault();
    // fault visible before the sweep ends
    load_good(); tc[1] = tc[0] - 1;
    do_start();
    in_valid = 1'b1; in_volt = VW'(tv[0]); in_count = CW'(tc[0]); @(negedge clk);
    in_volt = VW'(tv[1]); in_count = CW'(tc[1]); @(negedge clk);
    in_valid = 1'b0;
    chk("R4", "early code", int'(fault_code), 1);
    chk("R3", "not done mid", int'(done), 0);
    @(negedge clk);
    in_valid = 1'b1; in_volt = 12'd1200; in_count = 16'd30000; in_last = 1'b1;
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    result("R9", 1, 1, 0);
  endtask

  task automatic t_single();
    tv[0] = 500; tc[0] = 10;
    do_start(); sweep(1); result("R10", 0, 0, 1);
  endtask

  task automatic t_ignore();
    // after done, offered entries that would be faults change nothing
    load_good(); do_start(); sweep(4);
    in_valid = 1'b1; in_volt = 12'd0; in_count = 16'd0; in_last = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    result("R3", 0, 0, 1);
  endtask

  task automatic t_restart();
    tv[0]=999; tv[1]=1007; tc[0]=21391; tc[1]=21389;
    do_start(); sweep(2); result("R4", 1, 1, 0);
    do_start();
    chk("R2", "code cleared", int'(fault_code), 0);
    chk("R2", "done cleared", int'(done), 0);
    chk("R2", "pass cleared", int'(pass), 0);
    load_good(); sweep(4); result("R2", 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_dec();
    t_flat();
    t_vord();
    t_low();
    t_high();
    t_edges();
    t_first();
    t_midfault();
    t_single();
    t_ignore();
    t_restart();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule